// File: doc/BRIEF.md
# Byte-Parity Cache Data Checker

This block guards the data arrays of a level-one instruction cache and a level-one data cache with byte parity. When a line is written, it produces one even-parity bit for each byte of the 64-bit word. On the data side it produces one further bit that protects the dirty flag, which is stored in the same array. The cache stores these bits next to the data. When the word is read back, the block recomputes parity and compares it with the stored bits.

The two sides report a mismatch in different ways. An instruction fetch that fails its check returns its word with a precise prefetch abort in the same beat, so the fetch unit can fault that exact instruction. A data read that fails its check returns its data normally. One cycle later it raises a sticky imprecise-abort flag, which stays high until the core acknowledges it. A syndrome register records which byte lanes failed, whether the dirty bit failed, and which side failed. It does this for the first error only, and the acknowledge clears it so that it can capture again.

Top module: `cacheParityGuard`

## Requirements
- R1: On the write paths, parity bit i of each generated vector equals the XOR of data bits 8i+7 down to 8i (even parity). The output is combinational from the write data.
- R2: The dirty parity bit generated on the data write path equals the dirty flag, because even parity over a single bit is the bit itself.
- R3: An instruction read taken with icRdValid high returns instrValid high and instrWord equal to the read data one clock later. With icRdValid low, instrValid is low one clock later.
- R4: prefetchAbort is high in exactly the beat where instrValid returns a word whose byte lane i parity differs from stored bit i, for any lane. An instruction-side error never raises dataAbortPend.
- R5: A data read taken with dcRdValid high returns dataValid, dataWord and dataDirty one clock later, and no abort appears in that beat.
- R6: dataAbortPend rises one clock after the returned data beat when any data lane or the dirty parity mismatched. It stays high until abortAck is sampled high, and it falls on the following clock. A new data error in the same cycle as abortAck keeps it set.
- R7: The syndrome is captured one clock after the returned beat of the first failing read. synLaneMask bit i marks lane i, synDirtyErr marks the dirty bit, and synFromData is 1 for the data side. When both sides fail together, the instruction side is recorded.
- R8: While synValid is high, later errors do not change the syndrome. abortAck clears synValid, synLaneMask, synDirtyErr and synFromData on the next clock, unless a new error is captured in that same clock.
- R9: A read with its valid low is ignored whatever its data and parity: no abort, no pending flag and no syndrome.
- R10: After reset, instrValid, prefetchAbort, dataValid, dataAbortPend, synValid, synLaneMask, synDirtyErr and synFromData are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| icWrData | input | 64 | Instruction cache write word |
| icWrParity | output | 8 | Per-byte parity to store with icWrData |
| dcWrData | input | 64 | Data cache write word |
| dcWrDirty | input | 1 | Dirty flag written with the line |
| dcWrParity | output | 8 | Per-byte parity to store with dcWrData |
| dcWrDirtyPar | output | 1 | Parity to store with the dirty flag |
| icRdValid | input | 1 | Instruction array read is valid |
| icRdData | input | 64 | Word read from the instruction array |
| icRdParity | input | 8 | Stored parity read with icRdData |
| instrValid | output | 1 | Returned instruction word is valid |
| instrWord | output | 64 | Returned instruction word |
| prefetchAbort | output | 1 | Precise abort aligned with instrWord |
| dcRdValid | input | 1 | Data array read is valid |
| dcRdData | input | 64 | Word read from the data array |
| dcRdDirty | input | 1 | Dirty flag read from the data array |
| dcRdParity | input | 8 | Stored per-byte parity of dcRdData |
| dcRdDirtyPar | input | 1 | Stored parity of the dirty flag |
| dataValid | output | 1 | Returned data word is valid |
| dataWord | output | 64 | Returned data word |
| dataDirty | output | 1 | Returned dirty flag |
| dataAbortPend | output | 1 | Sticky imprecise data abort |
| abortAck | input | 1 | Clears the pending abort and rearms the syndrome |
| synValid | output | 1 | Syndrome holds a captured error |
| synLaneMask | output | 8 | Failing byte lanes of the first error |
| synDirtyErr | output | 1 | Dirty parity failed in the first error |
| synFromData | output | 1 | First error came from the data side |

## Verification
A bad stage register would show at once: a wrong word, a missing valid or a misplaced prefetch abort appears on the beat after the read. A fault in the pending flag or the syndrome capture shows one clock later, as a pending flag that fails to rise, fails to hold across idle cycles, or fails to clear after an acknowledge. It can also show as a syndrome that a second error overwrites. A lane or side mix-up shows up as a wrong bit in synLaneMask or a wrong synFromData on the first capture after an acknowledge.

// File: rtl/cpgPkg.sv
package cpgPkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic synCapture; // load syndrome from the check stage
    logic synClear;   // wipe the syndrome
    logic takeData;   // capture from the data side rather than the instruction side
  } cpgStrobes_t;
endpackage

// File: rtl/cpgLaneParity.sv
module cpgLaneParity #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] word,
  output logic [LANES-1:0]  par
);
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign par[g] = ^word[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/cpgDatapath.sv
module cpgDatapath
  import cpgPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] icWrData,
  output logic [LANES-1:0]  icWrParity,
  input  logic [DATA_W-1:0] dcWrData,
  input  logic              dcWrDirty,
  output logic [LANES-1:0]  dcWrParity,
  output logic              dcWrDirtyPar,
  input  logic              icRdValid,
  input  logic [DATA_W-1:0] icRdData,
  input  logic [LANES-1:0]  icRdParity,
  output logic              instrValid,
  output logic [DATA_W-1:0] instrWord,
  output logic              prefetchAbort,
  input  logic              dcRdValid,
  input  logic [DATA_W-1:0] dcRdData,
  input  logic              dcRdDirty,
  input  logic [LANES-1:0]  dcRdParity,
  input  logic              dcRdDirtyPar,
  output logic              dataValid,
  output logic [DATA_W-1:0] dataWord,
  output logic              dataDirty,
  input  cpgStrobes_t       strobes,
  output logic              icErrQ,
  output logic              dcErrQ,
  output logic [LANES-1:0]  synLaneMask,
  output logic              synDirtyErr,
  output logic              synFromData
);
  logic [LANES-1:0] icRdCalc, dcRdCalc;
  logic [LANES-1:0] icLaneErr, dcLaneErr;
  logic             dcDirtyErr;
  logic [LANES-1:0] icMaskQ, dcMaskQ;
  logic             dcDirtyErrQ;

  cpgLaneParity #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_genIc (.word(icWrData), .par(icWrParity));
  cpgLaneParity #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_genDc (.word(dcWrData), .par(dcWrParity));
  cpgLaneParity #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_chkIc (.word(icRdData), .par(icRdCalc));
  cpgLaneParity #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_chkDc (.word(dcRdData), .par(dcRdCalc));

  // even parity over one bit is the bit itself
  assign dcWrDirtyPar = dcWrDirty;

  always_comb begin
    icLaneErr  = icRdValid ? (icRdCalc ^ icRdParity) : '0;
    dcLaneErr  = dcRdValid ? (dcRdCalc ^ dcRdParity) : '0;
    dcDirtyErr = dcRdValid & (dcRdDirty ^ dcRdDirtyPar);
  end

  // return stage: word, flag and precise abort leave together
  always_ff @(posedge clk) begin
    if (!rstN) begin
      instrValid    <= 1'b0;
      instrWord     <= '0;
      prefetchAbort <= 1'b0;
      icMaskQ       <= '0;
      dataValid     <= 1'b0;
      dataWord      <= '0;
      dataDirty     <= 1'b0;
      dcMaskQ       <= '0;
      dcDirtyErrQ   <= 1'b0;
    end else begin
      instrValid    <= icRdValid;
      instrWord     <= icRdData;
      prefetchAbort <= |icLaneErr;
      icMaskQ       <= icLaneErr;
      dataValid     <= dcRdValid;
      dataWord      <= dcRdData;
      dataDirty     <= dcRdDirty;
      dcMaskQ       <= dcLaneErr;
      dcDirtyErrQ   <= dcDirtyErr;
    end
  end

  assign icErrQ = |icMaskQ;
  assign dcErrQ = (|dcMaskQ) | dcDirtyErrQ;

  // syndrome record
  always_ff @(posedge clk) begin
    if (!rstN) begin
      synLaneMask <= '0;
      synDirtyErr <= 1'b0;
      synFromData <= 1'b0;
    end else if (strobes.synCapture) begin
      synLaneMask <= strobes.takeData ? dcMaskQ : icMaskQ;
      synDirtyErr <= strobes.takeData & dcDirtyErrQ;
      synFromData <= strobes.takeData;
    end else if (strobes.synClear) begin
      synLaneMask <= '0;
      synDirtyErr <= 1'b0;
      synFromData <= 1'b0;
    end
  end

  p_abort_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    prefetchAbort |-> instrValid);
  p_instr_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    !icRdValid |=> (!instrValid && !prefetchAbort));
  p_data_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    dcRdValid |=> dataValid);
  p_syn_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.synCapture && !strobes.synClear) |=> $stable(synLaneMask));
endmodule

// File: rtl/cpgControl.sv
module cpgControl
  import cpgPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        icErrQ,
  input  logic        dcErrQ,
  input  logic        abortAck,
  output cpgStrobes_t strobes,
  output logic        dataAbortPend,
  output logic        synValid
);
  logic anyErr;

  always_comb begin
    anyErr             = icErrQ | dcErrQ;
    strobes.synCapture = anyErr & (~synValid | abortAck);
    strobes.synClear   = abortAck & ~strobes.synCapture;
    strobes.takeData   = ~icErrQ; // instruction side wins a tie
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataAbortPend <= 1'b0;
      synValid      <= 1'b0;
    end else begin
      if (dcErrQ)        dataAbortPend <= 1'b1;
      else if (abortAck) dataAbortPend <= 1'b0;
      if (strobes.synCapture)    synValid <= 1'b1;
      else if (strobes.synClear) synValid <= 1'b0;
    end
  end

  p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataAbortPend && !abortAck) |=> dataAbortPend);
  p_pend_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataAbortPend) |-> $past(dcErrQ));
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (abortAck && !dcErrQ) |=> !dataAbortPend);
  p_first_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    (synValid && !abortAck) |=> synValid);
endmodule

// File: rtl/cacheParityGuard.sv
module cacheParityGuard
  import cpgPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] icWrData,
  output logic [LANES-1:0]  icWrParity,
  input  logic [DATA_W-1:0] dcWrData,
  input  logic              dcWrDirty,
  output logic [LANES-1:0]  dcWrParity,
  output logic              dcWrDirtyPar,
  input  logic              icRdValid,
  input  logic [DATA_W-1:0] icRdData,
  input  logic [LANES-1:0]  icRdParity,
  output logic              instrValid,
  output logic [DATA_W-1:0] instrWord,
  output logic              prefetchAbort,
  input  logic              dcRdValid,
  input  logic [DATA_W-1:0] dcRdData,
  input  logic              dcRdDirty,
  input  logic [LANES-1:0]  dcRdParity,
  input  logic              dcRdDirtyPar,
  output logic              dataValid,
  output logic [DATA_W-1:0] dataWord,
  output logic              dataDirty,
  output logic              dataAbortPend,
  input  logic              abortAck,
  output logic              synValid,
  output logic [LANES-1:0]  synLaneMask,
  output logic              synDirtyErr,
  output logic              synFromData
);
  cpgStrobes_t strobes;
  logic        icErrQ, dcErrQ;

  cpgDatapath #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_dp (
    .clk(clk), .rstN(rstN),
    .icWrData(icWrData), .icWrParity(icWrParity),
    .dcWrData(dcWrData), .dcWrDirty(dcWrDirty),
    .dcWrParity(dcWrParity), .dcWrDirtyPar(dcWrDirtyPar),
    .icRdValid(icRdValid), .icRdData(icRdData), .icRdParity(icRdParity),
    .instrValid(instrValid), .instrWord(instrWord), .prefetchAbort(prefetchAbort),
    .dcRdValid(dcRdValid), .dcRdData(dcRdData), .dcRdDirty(dcRdDirty),
    .dcRdParity(dcRdParity), .dcRdDirtyPar(dcRdDirtyPar),
    .dataValid(dataValid), .dataWord(dataWord), .dataDirty(dataDirty),
    .strobes(strobes), .icErrQ(icErrQ), .dcErrQ(dcErrQ),
    .synLaneMask(synLaneMask), .synDirtyErr(synDirtyErr), .synFromData(synFromData)
  );

  cpgControl i_ctl (
    .clk(clk), .rstN(rstN),
    .icErrQ(icErrQ), .dcErrQ(dcErrQ), .abortAck(abortAck),
    .strobes(strobes), .dataAbortPend(dataAbortPend), .synValid(synValid)
  );
endmodule

// File: tb/test_cacheParityGuard.sv
module test_cacheParityGuard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] icWrData = '0, dcWrData = '0, icRdData = '0, dcRdData = '0;
  logic        dcWrDirty = 1'b0, icRdValid = 1'b0, dcRdValid = 1'b0;
  logic        dcRdDirty = 1'b0, dcRdDirtyPar = 1'b0, abortAck = 1'b0;
  logic [7:0]  icRdParity = '0, dcRdParity = '0;
  logic [7:0]  icWrParity, dcWrParity, synLaneMask;
  logic        dcWrDirtyPar, instrValid, prefetchAbort, dataValid, dataDirty;
  logic        dataAbortPend, synValid, synDirtyErr, synFromData;
  logic [63:0] instrWord, dataWord;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cacheParityGuard i_cacheParityGuard (
    .clk(clk), .rstN(rstN),
    .icWrData(icWrData), .icWrParity(icWrParity),
    .dcWrData(dcWrData), .dcWrDirty(dcWrDirty),
    .dcWrParity(dcWrParity), .dcWrDirtyPar(dcWrDirtyPar),
    .icRdValid(icRdValid), .icRdData(icRdData), .icRdParity(icRdParity),
    .instrValid(instrValid), .instrWord(instrWord), .prefetchAbort(prefetchAbort),
    .dcRdValid(dcRdValid), .dcRdData(dcRdData), .dcRdDirty(dcRdDirty),
    .dcRdParity(dcRdParity), .dcRdDirtyPar(dcRdDirtyPar),
    .dataValid(dataValid), .dataWord(dataWord), .dataDirty(dataDirty),
    .dataAbortPend(dataAbortPend), .abortAck(abortAck),
    .synValid(synValid), .synLaneMask(synLaneMask),
    .synDirtyErr(synDirtyErr), .synFromData(synFromData)
  );

  // vector: [74] data side, [73:10] word, [9:2] lane flips, [1] dirty, [0] dirty flip
  localparam logic [74:0] VECS [0:5] = '{
    {1'b0, 64'h0123456789ABCDEF, 8'h00, 1'b0, 1'b0},
    {1'b0, 64'hFFFF0000A5A55A5A, 8'h04, 1'b0, 1'b0},
    {1'b1, 64'hDEADBEEFCAFEF00D, 8'h00, 1'b1, 1'b0},
    {1'b1, 64'h0000000000000001, 8'h81, 1'b0, 1'b0},
    {1'b1, 64'h1122334455667788, 8'h00, 1'b1, 1'b1},
    {1'b0, 64'hFFFFFFFFFFFFFFFF, 8'hFF, 1'b0, 1'b0}
  };

  function automatic logic [7:0] benchPar(input logic [63:0] w);
    logic [7:0] p = '0;
    for (int l = 0; l < 8; l++)
      for (int b = 0; b < 8; b++)
        p[l] = p[l] ^ w[l*8+b];
    return p;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ackCycle();
    @(negedge clk); abortAck = 1'b1;
    @(negedge clk); abortAck = 1'b0;
  endtask

  task automatic driveIc(input logic [63:0] w, input logic [7:0] flip);
    icRdValid = 1'b1; icRdData = w; icRdParity = benchPar(w) ^ flip;
  endtask

  task automatic driveDc(input logic [63:0] w, input logic [7:0] flip,
                         input logic d, input logic dflip);
    dcRdValid = 1'b1; dcRdData = w; dcRdParity = benchPar(w) ^ flip;
    dcRdDirty = d; dcRdDirtyPar = d ^ dflip;
  endtask

  task automatic idleReads();
    icRdValid = 1'b0; dcRdValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 instrValid", instrValid, 0);
    chk("R10 prefetchAbort", prefetchAbort, 0);
    chk("R10 dataValid", dataValid, 0);
    chk("R10 pend", dataAbortPend, 0);
    chk("R10 syn", {synValid, synLaneMask, synDirtyErr, synFromData}, 0);

    for (int v = 0; v < 6; v++) begin
      logic        side  = VECS[v][74];
      logic [63:0] w     = VECS[v][73:10];
      logic [7:0]  flip  = VECS[v][9:2];
      logic        d     = VECS[v][1];
      logic        dflip = VECS[v][0];
      logic        expErr = side ? ((flip != 0) || dflip) : (flip != 0);
      @(negedge clk);
      icWrData = w; dcWrData = ~w; dcWrDirty = d;
      #1;
      chk("R1 ic write parity", icWrParity, benchPar(w));
      chk("R1 dc write parity", dcWrParity, benchPar(~w));
      chk("R2 dirty parity", dcWrDirtyPar, d);
      if (side) driveDc(w, flip, d, dflip); else driveIc(w, flip);
      @(negedge clk);
      idleReads();
      if (!side) begin
        chk("R3 instrValid", instrValid, 1);
        chk("R3 instrWord", instrWord, w);
        chk("R4 prefetchAbort", prefetchAbort, flip != 0);
      end else begin
        chk("R5 dataValid", dataValid, 1);
        chk("R5 dataWord", dataWord, w);
        chk("R5 dataDirty", dataDirty, d);
        chk("R5 no abort in beat", {prefetchAbort, dataAbortPend}, 0);
      end
      @(negedge clk);
      chk("R6 pend", dataAbortPend, side & expErr);
      chk("R7 synValid", synValid, expErr);
      chk("R7 synLaneMask", synLaneMask, expErr ? flip : 8'h00);
      chk("R7 synDirtyErr", synDirtyErr, side & dflip);
      chk("R7 synFromData", synFromData, side & expErr);
      abortAck = 1'b1;
      @(negedge clk);
      abortAck = 1'b0;
      chk("R6 ack clears pend", dataAbortPend, 0);
      chk("R8 ack clears syn", {synValid, synLaneMask, synDirtyErr, synFromData}, 0);
    end

    // R9 reads with valid low carry bad parity but are ignored
    @(negedge clk);
    icRdData = 64'h55; icRdParity = 8'hFF; dcRdData = 64'h77; dcRdParity = 8'hFF;
    dcRdDirty = 1'b1; dcRdDirtyPar = 1'b0;
    @(negedge clk);
    chk("R9 no instr", {instrValid, prefetchAbort}, 0);
    chk("R9 no data", dataValid, 0);
    @(negedge clk);
    chk("R9 no pend", dataAbortPend, 0);
    chk("R9 no syn", synValid, 0);

    // R6 and R8: first error kept, pending held through idle cycles
    driveDc(64'hAAAA, 8'h10, 1'b0, 1'b0);
    @(negedge clk); driveDc(64'hBBBB, 8'h02, 1'b0, 1'b1);
    @(negedge clk); idleReads();
    chk("R8 first syndrome", synLaneMask, 8'h10);
    repeat (3) @(negedge clk);
    chk("R6 pend sticky", dataAbortPend, 1);
    chk("R8 syndrome kept", {synLaneMask, synDirtyErr}, {8'h10, 1'b0});
    ackCycle();
    chk("R6 pend cleared", dataAbortPend, 0);
    chk("R8 syndrome cleared", synValid, 0);

    // R7 both sides fail together: instruction side recorded, data pend raised
    @(negedge clk);
    driveIc(64'h1234, 8'h20); driveDc(64'h5678, 8'h40, 1'b0, 1'b0);
    @(negedge clk); idleReads();
    chk("R4 abort on tie", prefetchAbort, 1);
    @(negedge clk);
    chk("R7 tie mask", synLaneMask, 8'h20);
    chk("R7 tie side", synFromData, 0);
    chk("R6 tie pend", dataAbortPend, 1);
    ackCycle();

    // R4 instruction error alone never raises pend
    @(negedge clk); driveIc(64'h9, 8'h01);
    @(negedge clk); idleReads();
    @(negedge clk);
    chk("R4 no pend from instr", dataAbortPend, 0);
    ackCycle();

    // R6 new data error in the ack cycle keeps pend set, syndrome captured
    @(negedge clk); driveDc(64'hC3, 8'h01, 1'b0, 1'b0);
    @(negedge clk); idleReads(); abortAck = 1'b1;
    @(negedge clk); abortAck = 1'b0;
    chk("R6 set wins over ack", dataAbortPend, 1);
    chk("R8 capture with ack", {synValid, synLaneMask}, {1'b1, 8'h01});
    ackCycle();
    chk("R6 final clear", dataAbortPend, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule